// File: doc/BRIEF.md
# Address Quadrant Context Selector

This block sits in front of a radix page-table walker. For every memory access it decides whether address translation takes place at all and, when it does, which partition and process context the walker must use. It looks at the two most significant bits of the effective address (the quadrant), the privilege state of the processor (hypervisor or guest), and the relocation enable that matches the access kind. From these it produces a partition ID, a process ID and two flags: one for the process-scoped stage and one for the partition-scoped stage.

In hypervisor state with relocation off, no walk is needed. The block forms the physical address directly and marks the result as a bypass. Guests may use only two of the four quadrants. An access by a guest to either of the other two raises a segment fault, which is reported as an instruction fault or a data fault according to the access kind. A data fault also captures the faulting address.

Each request carries a valid strobe. The complete decision appears on registered outputs one clock later, with its own valid strobe, so back-to-back requests are accepted every cycle.

Top module: `quad_ctx_sel`

## Requirements
- R1: `rsp_vld` is `req_vld` delayed by exactly one clock. All outputs are 0 while reset is applied.
- R2: In hypervisor state, when the request is neither bypassed nor faulted, the quadrant `ea[63:62]` selects the context. Quadrant 0 gives partition 0 with `cur_pid`. Quadrant 1 gives `cur_lpid` with `cur_pid`. Quadrant 2 gives `cur_lpid` with process 0. Quadrant 3 gives partition 0 with process 0.
- R3: In guest state, quadrant 0 gives `cur_lpid` with `cur_pid`, and quadrant 3 gives `cur_lpid` with process 0.
- R4: In guest state, quadrants 1 and 2 raise a segment fault. The response then has both translation flags clear, and its partition and process IDs are 0.
- R5: A segment fault on a fetch (`acc_type` = 2) sets `rsp_iseg_fault`, with `rsp_fault_addr` = 0. A segment fault on a read (0) or a write (1) sets `rsp_dseg_fault`, with `rsp_fault_addr` equal to the effective address.
- R6: Relocation follows `inst_reloc` for a fetch and `data_reloc` for a read or a write. On a non-faulted, non-bypassed response, `rsp_proc_xlate` equals that relocation value.
- R7: In hypervisor state with relocation off, `rsp_bypass` is set. `rsp_raddr` is the effective address with bits 63:60 cleared, ORed with `rmo_offset` only when `ea[63]` is 0. The IDs are 0 and both translation flags are clear.
- R8: On a non-faulted, non-bypassed response, `rsp_part_xlate` is 1 when the selected partition ID is nonzero or the processor is in guest state. Otherwise it is 0.
- R9: `acc_type` = 3 sets `rsp_bad_type`. All other flags are clear and the IDs and addresses are 0.
- R10: At most one of `rsp_iseg_fault`, `rsp_dseg_fault`, `rsp_bypass` and `rsp_bad_type` is set in any response. `rsp_raddr` is 0 unless `rsp_bypass` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_ea | input | EA_W | Effective address |
| hv_mode | input | 1 | 1 = hypervisor state, 0 = guest |
| inst_reloc | input | 1 | Relocation enable for fetches |
| data_reloc | input | 1 | Relocation enable for reads and writes |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 illegal |
| cur_lpid | input | LPID_W | Current partition ID |
| cur_pid | input | PID_W | Current process ID |
| rmo_offset | input | EA_W | Real-mode offset |
| rsp_vld | output | 1 | Response strobe |
| rsp_lpid | output | LPID_W | Selected partition ID |
| rsp_pid | output | PID_W | Selected process ID |
| rsp_proc_xlate | output | 1 | Run process-scoped translation |
| rsp_part_xlate | output | 1 | Run partition-scoped translation |
| rsp_bypass | output | 1 | Real-mode bypass; `rsp_raddr` is final |
| rsp_raddr | output | EA_W | Real-mode physical address |
| rsp_iseg_fault | output | 1 | Instruction segment fault |
| rsp_dseg_fault | output | 1 | Data segment fault |
| rsp_fault_addr | output | EA_W | Captured address of a data segment fault |
| rsp_bad_type | output | 1 | Illegal access-type code |

## Verification
The bench builds the block with its default widths: a 64-bit effective address, a 12-bit partition ID and a 20-bit process ID. At full address width, the quadrant bits, the clearing of bits 63:60 and the test of bit 63 that gates the offset all sit in their real positions, so addresses both below and above the top bit are tried. A nonzero offset and a partition ID that switches between zero and nonzero make both outcomes of the offset merge and of the partition-stage decision observable. Requests are issued back to back and also after idle gaps, which exercises the one-cycle response strobe.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    QD_ZERO  = 2'd0,
    QD_ONE   = 2'd1,
    QD_TWO   = 2'd2,
    QD_THREE = 2'd3
  } quad_e;
endpackage

// File: rtl/qcs_quad_map.sv
module qcs_quad_map
  import qcs_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [1:0]        quad,
  input  logic              hv,
  input  logic [LPID_W-1:0] lpid_in,
  input  logic [PID_W-1:0]  pid_in,
  output logic [LPID_W-1:0] lpid_out,
  output logic [PID_W-1:0]  pid_out,
  output logic              illegal
);
  always_comb begin
    lpid_out = '0;
    pid_out  = '0;
    illegal  = 1'b0;
    if (hv) begin
      unique case (quad_e'(quad))
        QD_ZERO:  pid_out = pid_in;
        QD_ONE:   begin lpid_out = lpid_in; pid_out = pid_in; end
        QD_TWO:   lpid_out = lpid_in;
        QD_THREE: ;
        default:  ;
      endcase
    end else begin
      unique case (quad_e'(quad))
        QD_ZERO:  begin lpid_out = lpid_in; pid_out = pid_in; end
        QD_THREE: lpid_out = lpid_in;
        default:  illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/qcs_real_addr.sv
module qcs_real_addr #(
  parameter int EA_W  = 64,
  parameter int CLR_W = 4
) (
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] offset,
  output logic [EA_W-1:0] raddr
);
  logic [EA_W-1:0] masked;

  generate
    if (CLR_W > 0) begin : g_clr
      localparam logic [EA_W-1:0] KEEP = {{CLR_W{1'b0}}, {(EA_W-CLR_W){1'b1}}};
      assign masked = ea & KEEP;
    end else begin : g_pass
      assign masked = ea;
    end
  endgenerate

  // top address bit set: the offset is not applied
  assign raddr = masked | (ea[EA_W-1] ? '0 : offset);
endmodule

// File: rtl/quad_ctx_sel.sv
module quad_ctx_sel
  import qcs_pkg::*;
#(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20,
  parameter int CLR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              hv_mode,
  input  logic              inst_reloc,
  input  logic              data_reloc,
  input  logic [1:0]        acc_type,
  input  logic [LPID_W-1:0] cur_lpid,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic [EA_W-1:0]   rmo_offset,
  output logic              rsp_vld,
  output logic [LPID_W-1:0] rsp_lpid,
  output logic [PID_W-1:0]  rsp_pid,
  output logic              rsp_proc_xlate,
  output logic              rsp_part_xlate,
  output logic              rsp_bypass,
  output logic [EA_W-1:0]   rsp_raddr,
  output logic              rsp_iseg_fault,
  output logic              rsp_dseg_fault,
  output logic [EA_W-1:0]   rsp_fault_addr,
  output logic              rsp_bad_type
);
  localparam int QUAD_LSB = EA_W - 2;

  typedef struct packed {
    logic [LPID_W-1:0] lpid;
    logic [PID_W-1:0]  pid;
    logic              proc_x;
    logic              part_x;
    logic              bypass;
    logic [EA_W-1:0]   raddr;
    logic              iseg;
    logic              dseg;
    logic [EA_W-1:0]   faddr;
    logic              bad;
  } rsp_t;

  logic [LPID_W-1:0] map_lpid;
  logic [PID_W-1:0]  map_pid;
  logic              map_illegal;
  logic [EA_W-1:0]   real_addr;
  logic              is_fetch;
  logic              is_bad;
  logic              reloc;
  rsp_t              rsp_d, rsp_q;
  logic              vld_q;

  qcs_quad_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_map (
    .quad     (req_ea[EA_W-1:QUAD_LSB]),
    .hv       (hv_mode),
    .lpid_in  (cur_lpid),
    .pid_in   (cur_pid),
    .lpid_out (map_lpid),
    .pid_out  (map_pid),
    .illegal  (map_illegal)
  );

  qcs_real_addr #(.EA_W(EA_W), .CLR_W(CLR_W)) u_real (
    .ea     (req_ea),
    .offset (rmo_offset),
    .raddr  (real_addr)
  );

  assign is_fetch = (acc_e'(acc_type) == ACC_FETCH);
  assign is_bad   = (acc_e'(acc_type) == ACC_RSVD);
  assign reloc    = is_fetch ? inst_reloc : data_reloc;

  // next-state decision
  always_comb begin
    rsp_d = '0;
    if (is_bad) begin
      rsp_d.bad = 1'b1;
    end else if (!reloc && hv_mode) begin
      rsp_d.bypass = 1'b1;
      rsp_d.raddr  = real_addr;
    end else if (map_illegal) begin
      rsp_d.iseg  = is_fetch;
      rsp_d.dseg  = !is_fetch;
      rsp_d.faddr = is_fetch ? '0 : req_ea;
    end else begin
      rsp_d.lpid   = map_lpid;
      rsp_d.pid    = map_pid;
      rsp_d.proc_x = reloc;
      rsp_d.part_x = (|map_lpid) || !hv_mode;
    end
  end

  // register stage with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= req_vld;
      if (req_vld) begin
        rsp_q <= rsp_d;
      end
    end
  end

  assign rsp_vld        = vld_q;
  assign rsp_lpid       = rsp_q.lpid;
  assign rsp_pid        = rsp_q.pid;
  assign rsp_proc_xlate = rsp_q.proc_x;
  assign rsp_part_xlate = rsp_q.part_x;
  assign rsp_bypass     = rsp_q.bypass;
  assign rsp_raddr      = rsp_q.raddr;
  assign rsp_iseg_fault = rsp_q.iseg;
  assign rsp_dseg_fault = rsp_q.dseg;
  assign rsp_fault_addr = rsp_q.faddr;
  assign rsp_bad_type   = rsp_q.bad;

  // R1
  a_r1_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld == $past(req_vld));

  // R10
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_iseg_fault, rsp_dseg_fault, rsp_bypass, rsp_bad_type}));

  // R4
  a_r4_fault_no_xlate: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_iseg_fault || rsp_dseg_fault) |-> (!rsp_proc_xlate && !rsp_part_xlate));

  // R5
  a_r5_dseg_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !hv_mode && (acc_type == 2'd0 || acc_type == 2'd1) &&
     (req_ea[EA_W-1:QUAD_LSB] == 2'd1 || req_ea[EA_W-1:QUAD_LSB] == 2'd2))
    |=> (rsp_dseg_fault && rsp_fault_addr == $past(req_ea)));

  // R7
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && hv_mode && acc_type != 2'd3 &&
     !((acc_type == 2'd2) ? inst_reloc : data_reloc))
    |=> (rsp_bypass && !rsp_proc_xlate && !rsp_part_xlate));

  // R8
  a_r8_guest_part: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !hv_mode && acc_type != 2'd3 &&
     (req_ea[EA_W-1:QUAD_LSB] == 2'd0 || req_ea[EA_W-1:QUAD_LSB] == 2'd3))
    |=> rsp_part_xlate);

  // R9
  a_r9_bad_type: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && acc_type == 2'd3) |=> (rsp_bad_type && !rsp_proc_xlate && !rsp_part_xlate));
endmodule

// File: tb/sim_quad_ctx_sel.sv
module sim_quad_ctx_sel;
  localparam int EA_W   = 64;
  localparam int LPID_W = 12;
  localparam int PID_W  = 20;

  typedef struct {
    logic [LPID_W-1:0] lpid;
    logic [PID_W-1:0]  pid;
    logic              proc_x;
    logic              part_x;
    logic              bypass;
    logic [EA_W-1:0]   raddr;
    logic              iseg;
    logic              dseg;
    logic [EA_W-1:0]   faddr;
    logic              bad;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_vld;
  logic [EA_W-1:0]   req_ea;
  logic              hv_mode, inst_reloc, data_reloc;
  logic [1:0]        acc_type;
  logic [LPID_W-1:0] cur_lpid;
  logic [PID_W-1:0]  cur_pid;
  logic [EA_W-1:0]   rmo_offset;
  logic              rsp_vld;
  logic [LPID_W-1:0] rsp_lpid;
  logic [PID_W-1:0]  rsp_pid;
  logic              rsp_proc_xlate, rsp_part_xlate, rsp_bypass;
  logic [EA_W-1:0]   rsp_raddr;
  logic              rsp_iseg_fault, rsp_dseg_fault;
  logic [EA_W-1:0]   rsp_fault_addr;
  logic              rsp_bad_type;

  int n_vec = 0;
  int n_bad = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  quad_ctx_sel u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ea(req_ea),
    .hv_mode(hv_mode), .inst_reloc(inst_reloc), .data_reloc(data_reloc),
    .acc_type(acc_type), .cur_lpid(cur_lpid), .cur_pid(cur_pid),
    .rmo_offset(rmo_offset), .rsp_vld(rsp_vld), .rsp_lpid(rsp_lpid),
    .rsp_pid(rsp_pid), .rsp_proc_xlate(rsp_proc_xlate),
    .rsp_part_xlate(rsp_part_xlate), .rsp_bypass(rsp_bypass),
    .rsp_raddr(rsp_raddr), .rsp_iseg_fault(rsp_iseg_fault),
    .rsp_dseg_fault(rsp_dseg_fault), .rsp_fault_addr(rsp_fault_addr),
    .rsp_bad_type(rsp_bad_type)
  );

  // expected result built from the requirement text
  function automatic exp_t model(input logic [EA_W-1:0] ea, input logic hv,
                                 input logic ir, input logic dr, input logic [1:0] at,
                                 input logic [LPID_W-1:0] lp, input logic [PID_W-1:0] pd,
                                 input logic [EA_W-1:0] rmo, input string tag);
    exp_t e;
    logic rl;
    logic [1:0] q;
    e = '{lpid:'0, pid:'0, proc_x:0, part_x:0, bypass:0, raddr:'0,
          iseg:0, dseg:0, faddr:'0, bad:0, tag:tag};
    q  = ea[63:62];
    rl = (at == 2'd2) ? ir : dr;
    if (at == 2'd3) e.bad = 1'b1;
    else if (hv && !rl) begin
      e.bypass = 1'b1;
      e.raddr  = {4'h0, ea[59:0]} | (ea[63] ? 64'h0 : rmo);
    end else if (!hv && (q == 2'd1 || q == 2'd2)) begin
      if (at == 2'd2) e.iseg = 1'b1;
      else begin e.dseg = 1'b1; e.faddr = ea; end
    end else begin
      if (hv) begin
        e.lpid = (q == 2'd1 || q == 2'd2) ? lp : '0;
        e.pid  = (q == 2'd0 || q == 2'd1) ? pd : '0;
      end else begin
        e.lpid = lp;
        e.pid  = (q == 2'd0) ? pd : '0;
      end
      e.proc_x = rl;
      e.part_x = (e.lpid != 0) || !hv;
    end
    return e;
  endfunction

  task automatic drive(input logic [EA_W-1:0] ea, input logic hv, input logic ir,
                       input logic dr, input logic [1:0] at, input string tag);
    @(negedge clk);
    req_vld = 1'b1; req_ea = ea; hv_mode = hv; inst_reloc = ir;
    data_reloc = dr; acc_type = at;
    sb.push_back(model(ea, hv, ir, dr, at, cur_lpid, cur_pid, rmo_offset, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (sb.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R1: response strobe act=1 exp=0 (no request pending)");
      end else begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        bad = 0;
        n_vec++;
        if (rsp_lpid != e.lpid) begin bad = 1; $display("FAIL %s lpid act=%h exp=%h", e.tag, rsp_lpid, e.lpid); end
        if (rsp_pid != e.pid) begin bad = 1; $display("FAIL %s pid act=%h exp=%h", e.tag, rsp_pid, e.pid); end
        if (rsp_proc_xlate != e.proc_x) begin bad = 1; $display("FAIL %s proc act=%b exp=%b", e.tag, rsp_proc_xlate, e.proc_x); end
        if (rsp_part_xlate != e.part_x) begin bad = 1; $display("FAIL %s part act=%b exp=%b", e.tag, rsp_part_xlate, e.part_x); end
        if (rsp_bypass != e.bypass) begin bad = 1; $display("FAIL %s bypass act=%b exp=%b", e.tag, rsp_bypass, e.bypass); end
        if (rsp_raddr != e.raddr) begin bad = 1; $display("FAIL %s raddr act=%h exp=%h", e.tag, rsp_raddr, e.raddr); end
        if (rsp_iseg_fault != e.iseg) begin bad = 1; $display("FAIL %s iseg act=%b exp=%b", e.tag, rsp_iseg_fault, e.iseg); end
        if (rsp_dseg_fault != e.dseg) begin bad = 1; $display("FAIL %s dseg act=%b exp=%b", e.tag, rsp_dseg_fault, e.dseg); end
        if (rsp_fault_addr != e.faddr) begin bad = 1; $display("FAIL %s faddr act=%h exp=%h", e.tag, rsp_fault_addr, e.faddr); end
        if (rsp_bad_type != e.bad) begin bad = 1; $display("FAIL %s badtype act=%b exp=%b", e.tag, rsp_bad_type, e.bad); end
        if (bad) n_bad++;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_ea = '0; hv_mode = 1'b0;
    inst_reloc = 1'b0; data_reloc = 1'b0; acc_type = 2'd0;
    cur_lpid = 12'h05A; cur_pid = 20'h01234; rmo_offset = 64'h0000_0000_4000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_vec++;
    if (rsp_vld !== 1'b0 || rsp_raddr !== '0 || rsp_lpid !== '0 || rsp_bypass !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: vld=%b raddr=%h act, exp all zero", rsp_vld, rsp_raddr);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 / R8 hypervisor quadrants, back to back
    drive(64'h0000_0000_0000_1000, 1, 0, 1, 2'd0, "R2");
    drive(64'h4000_0000_0000_2000, 1, 0, 1, 2'd1, "R2");
    drive(64'h8000_0000_0000_3000, 1, 1, 0, 2'd2, "R2");
    drive(64'hC000_0000_0000_4000, 1, 0, 1, 2'd0, "R8");
    idle(1);
    cur_lpid = '0;
    drive(64'h4000_0000_0000_5000, 1, 0, 1, 2'd1, "R8");
    idle(1);
    cur_lpid = 12'h05A;
    // R3 guest legal quadrants
    drive(64'h0000_0000_0000_6000, 0, 0, 1, 2'd0, "R3");
    drive(64'hC000_0000_0000_7000, 0, 0, 1, 2'd1, "R3");
    // R4 / R5 guest illegal quadrants
    drive(64'h4000_0000_1234_5678, 0, 0, 1, 2'd0, "R5");
    drive(64'h8000_0000_0000_9ABC, 0, 1, 1, 2'd2, "R4");
    drive(64'h8000_0000_DEAD_0000, 0, 0, 1, 2'd1, "R5");
    idle(3);
    // R7 real-mode bypass, bit 63 clear and set
    drive(64'h3000_0000_0000_1000, 1, 1, 0, 2'd0, "R7");
    drive(64'hF000_0000_0000_2000, 1, 0, 1, 2'd2, "R7");
    drive(64'h7ABC_0000_0000_0010, 1, 1, 0, 2'd1, "R7");
    // R6 relocation source
    drive(64'h0000_0000_0000_8000, 1, 1, 0, 2'd2, "R6");
    drive(64'h0000_0000_0000_8000, 0, 1, 0, 2'd0, "R6");
    drive(64'hC000_0000_0000_8000, 0, 0, 1, 2'd2, "R6");
    // R9 illegal type
    drive(64'h4000_0000_0000_0001, 0, 1, 1, 2'd3, "R9");
    drive(64'h0000_0000_0000_0002, 1, 0, 0, 2'd3, "R9");
    // R10 alternation fault / bypass / normal
    drive(64'h4000_0000_0000_0100, 0, 0, 0, 2'd1, "R10");
    drive(64'h0000_0000_0000_0200, 1, 0, 0, 2'd1, "R10");
    drive(64'h0000_0000_0000_0300, 1, 0, 1, 2'd1, "R10");
    idle(4);
    // R1: no leftover expected responses
    n_vec++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 pending responses act=%0d exp=0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule